// File: doc/BRIEF.md
# Guarded Byte-Array Write Controller

This block sits between a processor's register bus and a byte-addressable nonvolatile data array, and makes a write to the array hard to start by accident. Before the array sees a write strobe, software must have set a stored enable bit. It must then write a two-byte key to a key register, and only after that set a start bit. The power-up hold-off window must also have ended. Any break in the key sequence disarms it. One start consumes the unlock. A start attempt that is refused raises a sticky error flag.

Once a write starts, the controller captures the address and data registers. It gives the array a one-cycle write strobe with those captured values and reports busy for a fixed number of cycles. That count stands in for the real program time. Software polls the start bit, which reads back as busy, to learn when the write is done. A separate read bit copies the byte at the current address into the data register. The same bus may be driven by an external programming port, marked by a qualifier input. While the code-protect strap is high, every access from that port is refused, and local accesses are unaffected.

Register select codes are 0 = address, 1 = data, 2 = control, 3 = key. The control bits are: bit 0 read request (write only), bit 1 start on write and busy on read, bit 2 enable, bit 3 error. The key register reads as zero.

Top module: `nvm_write_guard`

## Requirements
- R1: After reset the enable, error and busy bits are 0, no array strobe is active, the address and data registers read 0 and the unlock sequencer is disarmed.
- R2: During the first PWRUP_CYCLES clock cycles after reset release, a start attempt never produces an array write strobe; it is refused and sets the error flag.
- R3: The unlock sequencer arms only when the key register receives 0x55 and then 0xAA with no other register write between them. A wrong value, or a write to another register after 0x55, returns it to disarmed.
- R4: A write to control with bit 1 set starts a write only if all of these hold: the stored enable was already 1, the written bit 2 is 1, the sequencer is armed, the hold-off has ended and no write is busy. The array write strobe is then high for exactly the one cycle after that clock edge. Clearing the enable (writing control with bit 2 = 0) makes a later start fail.
- R5: The control bit 1 reads 1 for exactly WRITE_CYCLES cycles starting at the start edge, then returns to 0.
- R6: Any control write with bit 1 set disarms the sequencer, so every start needs a fresh key sequence.
- R7: A refused start sets the error flag (control bit 3). It stays set until a control write with bit 3 = 0 clears it.
- R8: The array write address and data are taken from the registers at the start edge. They stay stable while busy, even if software rewrites the address or data registers.
- R9: A control write with bit 0 set while not busy raises the array read strobe in that cycle and loads the array byte at the current address into the data register. While busy the request is ignored.
- R10: When the code-protect strap is 1, accesses with the external qualifier set change no state and read as 0, while local accesses behave normally. With the strap at 0, external accesses work like local ones.
- R11: A start attempt while busy is ignored: no new strobe, no error, and the running write is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cp_strap | input | 1 | Code-protect strap; 1 refuses external-port accesses |
| bus_wr | input | 1 | Register write strobe |
| bus_ext | input | 1 | Access comes from the external programming port |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register |
| arr_re | output | 1 | Array read strobe (combinational) |
| arr_raddr | output | ADDR_W | Array read address |
| arr_rdata | input | 8 | Array read data, valid in the same cycle |
| arr_we | output | 1 | Array write strobe, one cycle per write |
| arr_waddr | output | ADDR_W | Captured write address |
| arr_wdata | output | 8 | Captured write data |

## Verification
The embedded properties check, on every cycle, the following:
- a write strobe is a single-cycle pulse inside a busy window and never comes before the hold-off ends;
- the captured address and data stay frozen while busy;
- a start disarms the sequencer;
- a refused start sets the error flag;
- a start during busy yields no strobe;
- a refused external access leaves the registers unchanged.

Some behaviour only the bench scenarios can show. One case is that a broken key order, an intervening register write or a cleared enable leads to a refused start. Another is that a write really lands in the array and reads back through the read bit. The busy window length and the full register readback are compared against a behavioural model on every clock.

// File: rtl/nvm_write_guard.sv
module nvm_write_guard #(
  parameter int ADDR_W       = 8,
  parameter int PWRUP_CYCLES = 9000000,
  parameter int WRITE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_strap,
  input  logic              bus_wr,
  input  logic              bus_ext,
  input  logic [1:0]        bus_sel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              arr_re,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata
);
  localparam int PCW = $clog2(PWRUP_CYCLES + 1);
  localparam int WCW = $clog2(WRITE_CYCLES + 1);
  localparam logic [PCW-1:0] PLIM  = PCW'(PWRUP_CYCLES);
  localparam logic [WCW-1:0] WLAST = WCW'(WRITE_CYCLES - 1);
  localparam logic [7:0] KEY_A = 8'h55;
  localparam logic [7:0] KEY_B = 8'hAA;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_e;

  key_e              key_q;
  logic              en_q, err_q, busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [PCW-1:0]    pcnt_q;
  logic [WCW-1:0]    wcnt_q;

  logic locked, acc, wr_addr, wr_data, wr_ctrl, wr_key;
  logic go_req, pwr_ok, ready, start, fail;

  assign locked  = bus_ext & cp_strap;
  assign acc     = bus_wr & ~locked;
  assign wr_addr = acc & (bus_sel == 2'd0);
  assign wr_data = acc & (bus_sel == 2'd1);
  assign wr_ctrl = acc & (bus_sel == 2'd2);
  assign wr_key  = acc & (bus_sel == 2'd3);
  assign go_req  = wr_ctrl & bus_wdata[1];
  assign pwr_ok  = (pcnt_q == PLIM);
  assign ready   = (key_q == K_ARMED) & en_q & bus_wdata[2] & pwr_ok;
  assign start   = go_req & ~busy_q & ready;
  assign fail    = go_req & ~busy_q & ~ready;

  assign arr_re    = wr_ctrl & bus_wdata[0] & ~busy_q;
  assign arr_raddr = addr_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (!locked) begin
      case (bus_sel)
        2'd0:    bus_rdata = 8'(addr_q);
        2'd1:    bus_rdata = data_q;
        2'd2:    bus_rdata = {4'b0000, err_q, en_q, busy_q, 1'b0};
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (!pwr_ok) pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= K_IDLE;
    end else if (wr_key) begin
      if (bus_wdata == KEY_A && key_q != K_HALF)      key_q <= K_HALF;
      else if (bus_wdata == KEY_B && key_q == K_HALF) key_q <= K_ARMED;
      else                                            key_q <= K_IDLE;
    end else if (go_req || (acc && key_q == K_HALF)) begin
      key_q <= K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_addr) addr_q <= ADDR_W'(bus_wdata);
      if (wr_data)     data_q <= bus_wdata;
      else if (arr_re) data_q <= arr_rdata;
      if (wr_ctrl) en_q <= bus_wdata[2];
      if (fail)                        err_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[3]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      wcnt_q    <= '0;
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we <= start;
      if (start) begin
        busy_q    <= 1'b1;
        wcnt_q    <= WLAST;
        arr_waddr <= addr_q;
        arr_wdata <= data_q;
      end else if (busy_q) begin
        if (wcnt_q == '0) busy_q <= 1'b0;
        else              wcnt_q <= wcnt_q - 1'b1;
      end
    end
  end

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);
  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy_q);
  p_no_early_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(pwr_ok));
  p_frozen_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !arr_we) |-> ($stable(arr_waddr) && $stable(arr_wdata)));
  p_unlock_spent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> (key_q == K_IDLE));
  p_err_on_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> err_q);
  p_busy_go_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && go_req) |=> !arr_we);
  p_ext_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && locked) |=> ($stable(en_q) && $stable(addr_q) && $stable(data_q) && $stable(busy_q)));
endmodule

// File: tb/test_nvm_write_guard.sv
module test_nvm_write_guard;
  localparam int AW = 8;
  localparam int P  = 40;
  localparam int W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp_strap = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_ext = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic arr_re, arr_we;
  logic [AW-1:0] arr_raddr, arr_waddr;
  logic [7:0] arr_rdata, arr_wdata;
  logic [7:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign arr_rdata = mem[arr_raddr];

  nvm_write_guard #(.ADDR_W(AW), .PWRUP_CYCLES(P), .WRITE_CYCLES(W)) i_nvm_write_guard (
    .clk(clk), .rst_n(rst_n), .cp_strap(cp_strap), .bus_wr(bus_wr), .bus_ext(bus_ext),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_re(arr_re), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata));

  int m_unlock, m_busy, m_pcnt;
  logic m_en, m_err, m_we;
  logic [7:0] m_addr, m_data, m_wa, m_wd;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic acc, bb, pok, ready;
    cycles++;
    if (!rst_n) begin
      m_unlock = 0; m_busy = 0; m_pcnt = 0;
      m_en = 0; m_err = 0; m_we = 0;
      m_addr = 0; m_data = 0; m_wa = 0; m_wd = 0;
    end else begin
      if (m_we) mem[m_wa] = m_wd;
      m_we = 0;
      bb = (m_busy > 0);
      pok = (m_pcnt == P);
      if (m_busy > 0) m_busy--;
      if (m_pcnt < P) m_pcnt++;
      acc = bus_wr && !(bus_ext && cp_strap);
      if (acc) begin
        if (bus_sel == 2'd3) begin
          if (bus_wdata == 8'h55 && m_unlock != 1) m_unlock = 1;
          else if (bus_wdata == 8'hAA && m_unlock == 1) m_unlock = 2;
          else m_unlock = 0;
        end else if (bus_sel == 2'd2) begin
          if (bus_wdata[1]) begin
            ready = (m_unlock == 2) && m_en && bus_wdata[2] && pok;
            if (!bb) begin
              if (ready) begin
                m_busy = W; m_we = 1; m_wa = m_addr; m_wd = m_data;
              end else m_err = 1;
            end else if (!bus_wdata[3]) m_err = 0;
            m_unlock = 0;
            if (!bb && !ready) m_err = 1;
            else if (!bus_wdata[3]) m_err = 0;
          end else begin
            if (m_unlock == 1) m_unlock = 0;
            if (!bus_wdata[3]) m_err = 0;
          end
          if (bus_wdata[0] && !bb) m_data = mem[m_addr];
          m_en = bus_wdata[2];
        end else begin
          if (m_unlock == 1) m_unlock = 0;
          if (bus_sel == 2'd0) m_addr = bus_wdata;
          else m_data = bus_wdata;
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] er;
    logic ere, lk;
    if (rst_n) begin
      lk = bus_ext && cp_strap;
      case (bus_sel)
        2'd0: er = m_addr;
        2'd1: er = m_data;
        2'd2: er = {4'b0000, m_err, m_en, (m_busy > 0), 1'b0};
        default: er = 8'h00;
      endcase
      if (lk) er = 8'h00;
      ere = bus_wr && !lk && bus_sel == 2'd2 && bus_wdata[0] && m_busy == 0;
      chk(arr_we == m_we, "R4 write strobe per cycle", arr_we, m_we);
      chk(arr_re == ere, "R9 read strobe per cycle", arr_re, ere);
      chk(bus_rdata == er, "R5 readback per cycle", bus_rdata, er);
      if (m_we) chk(arr_waddr == m_wa && arr_wdata == m_wd, "R8 write target", {arr_waddr, arr_wdata}, {m_wa, m_wd});
    end
  end

  task automatic put(input logic [1:0] s, input logic [7:0] v, input logic ext = 1'b0);
    @(negedge clk); #1;
    bus_sel = s; bus_wdata = v; bus_ext = ext; bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_ext = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v, input logic ext = 1'b0);
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_sel = s; bus_ext = ext;
    @(negedge clk);
    v = bus_rdata;
    #1 bus_ext = 1'b0;
  endtask

  task automatic unlock();
    put(2'd3, 8'h55);
    put(2'd3, 8'hAA);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 40; i++) begin
      peek(2'd2, v);
      if (!v[1]) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      chk(1'b0, "R1 watchdog expired", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    peek(2'd2, v); chk(v == 8'h00, "R1 control after reset", v, 8'h00);
    peek(2'd0, v); chk(v == 8'h00, "R1 address after reset", v, 8'h00);
    peek(2'd1, v); chk(v == 8'h00, "R1 data after reset", v, 8'h00);

    put(2'd2, 8'h04); unlock(); put(2'd2, 8'h06);
    peek(2'd2, v); chk(v == 8'h0C, "R2 start in hold-off refused", v, 8'h0C);

    repeat (P) @(negedge clk);
    put(2'd2, 8'h04);
    peek(2'd2, v); chk(v == 8'h04, "R7 error cleared", v, 8'h04);

    put(2'd0, 8'h12); put(2'd1, 8'hA5); unlock(); put(2'd2, 8'h06);
    peek(2'd2, v); chk(v == 8'h06, "R5 busy after start", v, 8'h06);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!bus_rdata[1]) break;
      n++;
    end
    chk(n < W, "R5 busy clears", n, W);
    chk(mem[8'h12] == 8'hA5, "R4 byte written", mem[8'h12], 8'hA5);
    put(2'd1, 8'h00); put(2'd2, 8'h05);
    peek(2'd1, v); chk(v == 8'hA5, "R9 read back via read bit", v, 8'hA5);

    put(2'd2, 8'h06);
    peek(2'd2, v); chk(v == 8'h0C, "R6 second start needs new key", v, 8'h0C);
    put(2'd2, 8'h04);

    put(2'd3, 8'h55); put(2'd3, 8'hAB); put(2'd2, 8'h06);
    peek(2'd2, v); chk(v == 8'h0C, "R3 wrong second key refused", v, 8'h0C);
    put(2'd2, 8'h04);
    put(2'd3, 8'h55); put(2'd1, 8'h00); put(2'd3, 8'hAA); put(2'd2, 8'h06);
    peek(2'd2, v); chk(v == 8'h0C, "R3 intervening write refused", v, 8'h0C);
    put(2'd2, 8'h04);

    put(2'd0, 8'h20); put(2'd1, 8'h3C); unlock(); put(2'd2, 8'h06);
    put(2'd0, 8'h21); put(2'd1, 8'h99);
    wait_idle();
    chk(mem[8'h20] == 8'h3C, "R8 captured data used", mem[8'h20], 8'h3C);
    chk(mem[8'h21] == (8'h21 ^ 8'h3C), "R8 new address untouched", mem[8'h21], 8'h21 ^ 8'h3C);

    put(2'd0, 8'h30); put(2'd1, 8'h77); unlock(); put(2'd2, 8'h06);
    put(2'd2, 8'h06);
    peek(2'd2, v); chk(v[3] == 1'b0, "R11 start while busy no error", v, v & 8'hF7);
    wait_idle();
    chk(mem[8'h30] == 8'h77, "R11 running write completes", mem[8'h30], 8'h77);

    cp_strap = 1'b1;
    put(2'd0, 8'h44, 1'b1);
    peek(2'd0, v); chk(v == 8'h30, "R10 external write refused", v, 8'h30);
    peek(2'd2, v, 1'b1); chk(v == 8'h00, "R10 external read is zero", v, 8'h00);
    put(2'd0, 8'h45);
    peek(2'd0, v); chk(v == 8'h45, "R10 local write allowed", v, 8'h45);
    unlock(); put(2'd2, 8'h06, 1'b1);
    peek(2'd2, v); chk(v == 8'h04, "R10 external start refused", v, 8'h04);
    cp_strap = 1'b0;
    put(2'd0, 8'h46, 1'b1);
    peek(2'd0, v, 1'b1); chk(v == 8'h46, "R10 external allowed unprotected", v, 8'h46);

    put(2'd2, 8'h00); unlock(); put(2'd2, 8'h06);
    peek(2'd2, v); chk(v == 8'h0C, "R4 start with enable clear refused", v, 8'h0C);
    chk(mem[8'h46] == (8'h46 ^ 8'h3C), "R4 no write when refused", mem[8'h46], 8'h46 ^ 8'h3C);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule